// File: doc/BRIEF.md
# Periodic Interval Timer

A free-running interval timer that sits on a simple synchronous register bus. The system clock is divided by sixteen to produce count steps. A 20-bit position counter moves forward by one on each step. When it reaches the programmed interval value it returns to zero. Each such return adds one to a 12-bit tally of completed periods and sets a sticky status flag. The flag can drive a level interrupt.

Software uses it as a periodic tick source. It programs the interval as the desired step count minus one and sets the enable bits. On each interrupt it reads the value register, which acknowledges the interrupt and returns how many periods have passed. Between interrupts it can read the image register at any time to get a fine-grained timestamp without disturbing the tally. When the enable bit is cleared, the counter does not stop at once. It finishes the period in progress and then parks at zero.

Top module: `periodic_interval_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While running, the position counter advances by one every 16 clock cycles. After the enabling write, the first advance lands on the 16th rising edge.
- R3: When a step arrives with the position at or above the interval value, the position returns to zero, the period tally gains one and status bit 0 is set. A period therefore lasts interval+1 steps.
- R4: The register map decodes a 4-bit byte address. The control register is at 0x0, with the interval in bits 19:0, the timer enable in bit 24 and the interrupt enable in bit 25; only these bits are stored and read back. Status is at 0x4, with the flag in bit 0. The acknowledging value register is at 0x8 and the passive image register is at 0xC. Both read as {tally[31:20], position[19:0]}. Unmapped reads return zero.
- R5: A read of 0x8 clears the period tally and the status flag on the following edge.
- R6: Reads of 0x4 and 0xC change nothing.
- R7: `irq` is the status flag gated by the interrupt-enable bit. It stays high until acknowledged. Clearing only the interrupt-enable bit masks `irq` while counting carries on undisturbed.
- R8: After the timer enable is cleared, stepping continues until the position returns to zero, which counts as a completed period. The position then holds at zero.
- R9: The period tally wraps modulo 4096.
- R10: If a period completes on the same edge that a 0x8 read takes effect, the read returns the old tally and the tally afterwards reads 1 with the flag set.
- R11: Writes to any address other than 0x0 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte address |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; read side effects apply at the rising edge |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_re` |
| irq | output | 1 | Level interrupt request |

## Verification
Directed sequences pin the exact edges where the first step lands, where a period closes, and where a drain after disable ends. These timings separate an off-by-one in the prescaler from one in the interval compare. A value read is placed exactly one edge before a period boundary, which shows whether a coinciding period is lost or double-counted. A run of 4097 short periods shows the tally wrapping. Seeded random intervals, interrupt-enable settings, wait lengths and mixes of image, status and value reads then compare every observed word against a timing model derived from the requirements. This shows that passive reads never disturb the tally while acknowledging reads always do.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int DATA_W  = 32;
  localparam int VAL_W   = 20;
  localparam int CNT_W   = 12;
  localparam int PRESC_W = 4;
  localparam int ADDR_W  = 4;
  localparam int EN_POS  = 24;
  localparam int IEN_POS = 25;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'h4;
  localparam logic [ADDR_W-1:0] A_VALUE = 4'h8;
  localparam logic [ADDR_W-1:0] A_IMAGE = 4'hC;

  typedef struct packed {
    logic             irq_en;
    logic             tmr_en;
    logic [VAL_W-1:0] ivl;
  } ctrl_t;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int PW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    if (run) ph_d = ph_q + 1'b1;
    else     ph_d = '0;
  end

  assign tick = run && (ph_q == {PW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  // R2: two steps never land on adjacent edges
  p_tick_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/pit_interval_ctr.sv
module pit_interval_ctr #(
  parameter int VW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          tmr_en,
  input  logic [VW-1:0] ivl,
  output logic          run,
  output logic          wrap,
  output logic [VW-1:0] pos
);
  logic [VW-1:0] pos_q, pos_d;

  assign run  = tmr_en || (pos_q != '0);
  assign wrap = tick && (pos_q >= ivl);
  assign pos  = pos_q;

  always_comb begin
    pos_d = pos_q;
    if (wrap)      pos_d = '0;
    else if (tick) pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> pos_q == '0);
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> pos_q == VW'($past(pos_q) + 1'b1));
  p_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pos_q == '0);
endmodule

// File: rtl/pit_period_tally.sv
module pit_period_tally #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrap,
  input  logic          ack,
  output logic [CW-1:0] cnt,
  output logic          flag
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;

  always_comb begin
    cnt_d  = ack ? '0 : cnt_q;
    if (wrap) cnt_d = cnt_d + 1'b1;
    flag_d = (flag_q && !ack) || wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wrap) |=> (cnt_q == '0) && !flag_q);
  p_ack_and_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && wrap) |=> (cnt_q == CW'(1)) && flag_q);
  p_count_mod_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !ack) |=> cnt_q == CW'($past(cnt_q) + 1'b1));
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !ack) |=> $stable(cnt_q) && $stable(flag_q));
endmodule

// File: rtl/periodic_interval_timer.sv
module periodic_interval_timer
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  ctrl_t            ctrl_q, ctrl_d;
  logic             ctrl_wr, ack;
  logic             run, tick, wrap, flag;
  logic [VAL_W-1:0] pos;
  logic [CNT_W-1:0] cnt;
  logic             wdata_unused;

  assign wdata_unused = ^{bus_wdata[DATA_W-1:IEN_POS+1], bus_wdata[EN_POS-1:VAL_W]};

  assign ctrl_wr = bus_we && (bus_addr == A_CTRL);
  assign ack     = bus_re && (bus_addr == A_VALUE);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.irq_en = bus_wdata[IEN_POS];
      ctrl_d.tmr_en = bus_wdata[EN_POS];
      ctrl_d.ivl    = bus_wdata[VAL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  pit_prescaler #(.PW(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  pit_interval_ctr #(.VW(VAL_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tmr_en(ctrl_q.tmr_en),
    .ivl(ctrl_q.ivl), .run(run), .wrap(wrap), .pos(pos)
  );

  pit_period_tally #(.CW(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .ack(ack), .cnt(cnt), .flag(flag)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      unique case (bus_addr)
        A_CTRL: begin
          bus_rdata[IEN_POS]   = ctrl_q.irq_en;
          bus_rdata[EN_POS]    = ctrl_q.tmr_en;
          bus_rdata[VAL_W-1:0] = ctrl_q.ivl;
        end
        A_STAT:           bus_rdata[0] = flag;
        A_VALUE, A_IMAGE: bus_rdata = {cnt, pos};
        default:          bus_rdata = '0;
      endcase
    end
  end

  assign irq = flag && ctrl_q.irq_en;

  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack && !ctrl_wr) |=> irq);
  p_other_wr_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr != A_CTRL)) |=> $stable(ctrl_q));
  p_rdata_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> bus_rdata == '0);
endmodule

// File: tb/periodic_interval_timer_tb_top.sv
`timescale 1ns/1ps
module periodic_interval_timer_tb_top;
  logic        clk, rst_n, we, re, irq;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;

  int cyc = 0, base = 0, clr_k = 0, kend = 1 << 30, pv = 0;
  int n_chk = 0, n_bad = 0;
  bit ien_m = 0, done = 0;

  localparam logic [31:0] EN = 32'h0100_0000, IEN = 32'h0200_0000;

  periodic_interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_re(re), .bus_rdata(rdata), .irq(irq)
  );

  initial clk = 0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ek(int k); return (k < kend) ? k : kend; endfunction
  function automatic int wraps(int k); return ek(k) / (16 * (pv + 1)); endfunction
  function automatic int curv(int k); return (ek(k) / 16) % (pv + 1); endfunction
  function automatic bit stat_exp(int k); return wraps(k) > wraps(clr_k); endfunction
  function automatic logic [31:0] word_exp(int k);
    int c;
    c = (wraps(k) - wraps(clr_k)) % 4096;
    return {c[11:0], 20'(curv(k))};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(posedge clk); #1; we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d, output logic i, output int k);
    @(negedge clk); addr = a; re = 1; #1;
    d = rdata; i = irq; k = cyc - base;
    @(posedge clk); #1; re = 0;
  endtask

  task automatic wait_k(int t);
    while (cyc - base < t) begin @(posedge clk); #1; end
  endtask

  task automatic img(string req);
    logic [31:0] d; logic i; int k;
    rd(4'hC, d, i, k);
    chk(req, d, word_exp(k));
    chk({req, " irq"}, {31'b0, i}, {31'b0, ien_m & stat_exp(k)});
  endtask

  task automatic val(string req);
    logic [31:0] d; logic i; int k;
    rd(4'h8, d, i, k);
    chk(req, d, word_exp(k));
    clr_k = ek(k);
  endtask

  task automatic stat(string req);
    logic [31:0] d; logic i; int k;
    rd(4'h4, d, i, k);
    chk(req, d, {31'b0, stat_exp(k)});
  endtask

  task automatic start(int p, bit ie);
    pv = p; ien_m = ie; kend = 1 << 30;
    wr(4'h0, EN | (ie ? IEN : 0) | 32'(p));
    base = cyc; clr_k = 0;
  endtask

  task automatic stop_and_clear();
    logic [31:0] d; logic i; int k;
    wr(4'h0, 0);
    repeat (16 * (pv + 1) + 40) @(posedge clk);
    #1;
    rd(4'h8, d, i, k);
    chk("R8 parked at zero", d & 32'h000F_FFFF, 0);
    rd(4'hC, d, i, k);
    chk("R5 cleared after drain", d, 0);
    ien_m = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] d; logic i; int k, kd;
    void'($urandom(32'd20240611));
    rst_n = 0; we = 0; re = 0; addr = 0; wdata = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), d, i, k);
      chk("R1 reset read", d, 0);
      chk("R1 reset irq", {31'b0, i}, 0);
    end
    // R4 only defined control bits stored
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d, i, k);
    chk("R4 ctrl readback", d, 32'h030F_FFFF);
    wr(4'h0, 0);
    rd(4'h0, d, i, k);
    chk("R4 ctrl cleared", d, 0);
    // R11 writes elsewhere ignored
    wr(4'h4, 32'hFFFF_FFFF); wr(4'h8, 32'hFFFF_FFFF); wr(4'hC, 32'h0300_0005);
    rd(4'h0, d, i, k);
    chk("R11 ctrl untouched", d, 0);
    rd(4'hC, d, i, k);
    chk("R11 counters untouched", d, 0);

    // R2/R3 basic timing, P=3, irq masked
    start(3, 0);
    wait_k(15); img("R2 before first step");
    img("R2 first step at 16");
    wait_k(63); img("R3 last step of period");
    img("R3 wrap at 64");
    img("R6 image keeps tally");
    stat("R6 status read passive");
    val("R5 value read");
    img("R5 tally cleared");
    stat("R5 flag cleared");
    // R10 value read right before a wrap
    wait_k(127); val("R10 read returns old tally");
    img("R10 wrap kept after clear");
    stat("R10 flag set");
    // R7 interrupt enable and mask
    wr(4'h0, EN | IEN | 3); ien_m = 1;
    wait_k(192); img("R7 irq raised");
    wr(4'h0, EN | 3); ien_m = 0;
    img("R7 masked, counting continues");
    wr(4'h0, EN | IEN | 3); ien_m = 1;
    val("R7 acknowledge");
    img("R7 irq dropped");
    wait_k(256); img("R7 irq next period");
    // R8 drain on disable
    wait_k(296);
    wr(4'h0, 3); ien_m = 0;
    kd = cyc - base;
    kend = (kd / 64 + 1) * 64;
    img("R8 still stepping after disable");
    wait_k(kd + 16); img("R8 stepping during drain");
    wait_k(kend + 60); img("R8 parked with period counted");
    wait_k(kend + 120); img("R8 holds at zero");
    stop_and_clear();

    // R9 tally modulo 4096, P=0
    start(0, 0);
    wait_k(65536); img("R9 tally wrapped to zero");
    stat("R9 flag set at wrap");
    wait_k(65552); img("R9 tally after 4097 periods");
    stop_and_clear();

    // random intervals, enables, waits and read mixes
    for (int it = 0; it < 8; it++) begin
      start(int'($urandom % 8), bit'($urandom % 2));
      for (int op = 0; op < 6; op++) begin
        repeat (1 + $urandom % 200) @(posedge clk);
        #1;
        case ($urandom % 3)
          0: img("R6 random image");
          1: val("R5 random value");
          default: stat("R3 random status");
        endcase
      end
      stop_and_clear();
    end
    done = 1;
    summary();
  end
endmodule